// File: doc/BRIEF.md
# Masked Dual Alarm Comparator

This block holds the decision logic for two time-of-day alarms in a real-time clock. On each once-per-second update strobe it compares the current BCD time against two sets of alarm values and sets a sticky flag for each alarm that matches. The time counters and the alarm and control storage live outside the block and arrive as plain inputs. Software clears a flag with a one-cycle clear pulse.

The first alarm compares seconds, minutes, hours and a day-or-date field. The second alarm has no seconds field and behaves as if its seconds value were fixed at 00. Bit 7 of every alarm byte is a mask bit, and a masked field always counts as matched. The masks must follow a hierarchy: a masked field means every finer field is masked as well. This gives repeat rates from once per second up to once per week or once per month. Bit 6 of each day-or-date alarm byte chooses whether that field is compared with the day of the week or with the date of the month.

Each flag is gated by its own enable and drives active-low interrupt pins. A routing input selects between two separate pins and one shared pin.

Top module: `dual_alarm_cmp`

## Requirements
- R1: A flag can only become set in the cycle after a cycle in which `tick_i` is 1. Between ticks, matching values have no effect on the flags.
- R2: For alarm 1 with all four mask bits (bit 7) at 0, the flag sets on a tick only when all of these match: `a1_sec_i[6:0]` equals the seconds, `a1_min_i[6:0]` equals the minutes, `a1_hour_i[6:0]` equals the hours, and the day/date field matches.
- R3: A mask bit of 1 makes its field match regardless of value. With only seconds masked, alarm 1 fires at any seconds value. With all four fields masked, it fires on every tick.
- R4: Bit 6 of a day/date alarm byte at 1 compares bits 5:0 with `now_day_i`. At 0 it compares bits 5:0 with `now_date_i`.
- R5: Alarm 2 sets its flag only on a tick where `now_sec_i` is 00. On such a tick it compares minutes, hours and day/date, using the same mask and select rules as alarm 1.
- R6: The hours compare uses all 7 low bits exactly as stored, including bit 6 (12/24 mode) and bit 5 (PM or tens of hours), with no conversion between formats. For example, 8'h72 does not match 8'h52.
- R7: A set flag stays set until a clear pulse (`a1_clr_i` / `a2_clr_i`). The flag output changes in the cycle after the tick or clear.
- R8: When a matching tick and a clear fall in the same cycle, the flag ends up set.
- R9: An interrupt pin is driven low only by an alarm whose flag and enable are both 1.
- R10: With `intcn_i`=0, gated alarm 1 drives `int_a_no` and gated alarm 2 drives `int_b_no`. With `intcn_i`=1, `int_a_no` is low when either gated alarm is active, and `int_b_no` stays high.
- R11: While reset is active, both flags are 0 and both pins are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Once-per-second update strobe |
| now_sec_i | input | 7 | Current seconds, BCD |
| now_min_i | input | 7 | Current minutes, BCD |
| now_hour_i | input | 7 | Current hours, BCD with mode and PM bits |
| now_day_i | input | 6 | Current day of week |
| now_date_i | input | 6 | Current date of month, BCD |
| a1_sec_i | input | 8 | Alarm 1 seconds: mask in bit 7, value in bits 6:0 |
| a1_min_i | input | 8 | Alarm 1 minutes: mask in bit 7 |
| a1_hour_i | input | 8 | Alarm 1 hours: mask in bit 7 |
| a1_dd_i | input | 8 | Alarm 1 day/date: mask in bit 7, select in bit 6, value in bits 5:0 |
| a2_min_i | input | 8 | Alarm 2 minutes: mask in bit 7 |
| a2_hour_i | input | 8 | Alarm 2 hours: mask in bit 7 |
| a2_dd_i | input | 8 | Alarm 2 day/date: same layout as alarm 1 |
| a1_ie_i | input | 1 | Alarm 1 interrupt enable |
| a2_ie_i | input | 1 | Alarm 2 interrupt enable |
| intcn_i | input | 1 | 1 = shared interrupt pin, 0 = separate pins |
| a1_clr_i | input | 1 | Alarm 1 flag clear pulse |
| a2_clr_i | input | 1 | Alarm 2 flag clear pulse |
| a1_flag_o | output | 1 | Alarm 1 sticky flag |
| a2_flag_o | output | 1 | Alarm 2 sticky flag |
| int_a_no | output | 1 | Interrupt pin A, active low |
| int_b_no | output | 1 | Interrupt pin B, active low |

## Verification
The assertions check the following on every cycle:
- flags rise only after a tick;
- flags hold until cleared, and drop after a clear that has no tick beside it;
- alarm 2 rises only after a tick with zero seconds;
- a fully unmasked exact match always sets alarm 1;
- disabled alarms never pull a pin low;
- shared routing keeps pin B high;
- reset values.

Some behaviours need chosen stimulus, and only the bench scenarios show them:
- the mask repeat patterns;
- the day-versus-date selection;
- the stored-format hours compare;
- the rule that a set beats a clear in the same cycle;
- which pin each alarm reaches.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned MASK_BIT = BYTE_W - 1;
  localparam int unsigned DYDT_BIT = BYTE_W - 2;
  localparam int unsigned VAL_W    = BYTE_W - 1;  // sec/min/hour compared bits
  localparam int unsigned DD_W     = BYTE_W - 2;  // day/date compared bits
  localparam int unsigned NUM_TOD  = 3;           // sec, min, hour

  typedef logic [BYTE_W-1:0] alm_byte_t;
  typedef logic [NUM_TOD-1:0][BYTE_W-1:0] tod_set_t;
  typedef logic [NUM_TOD-1:0][VAL_W-1:0]  tod_now_t;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
  parameter int unsigned CMP_W = 7
) (
  input  logic             mask_i,
  input  logic [CMP_W-1:0] set_i,
  input  logic [CMP_W-1:0] cur_i,
  output logic             hit_o
);
  assign hit_o = mask_i | (set_i == cur_i);
endmodule

// File: rtl/alarm_unit.sv
module alarm_unit
  import rtc_alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              clr_i,
  input  tod_set_t          tod_set_i,
  input  tod_now_t          tod_now_i,
  input  alm_byte_t         dd_set_i,
  input  logic [DD_W-1:0]   now_day_i,
  input  logic [DD_W-1:0]   now_date_i,
  output logic              flag_o
);
  logic [NUM_TOD-1:0] tod_hit;
  logic               dd_hit;
  logic [DD_W-1:0]    dd_cur;
  logic               match;
  logic               flag_q;

  for (genvar g = 0; g < NUM_TOD; g++) begin : g_tod
    alarm_field_cmp #(.CMP_W(VAL_W)) i_cmp (
      .mask_i (tod_set_i[g][MASK_BIT]),
      .set_i  (tod_set_i[g][VAL_W-1:0]),
      .cur_i  (tod_now_i[g]),
      .hit_o  (tod_hit[g])
    );
  end

  assign dd_cur = dd_set_i[DYDT_BIT] ? now_day_i : now_date_i;

  alarm_field_cmp #(.CMP_W(DD_W)) i_dd_cmp (
    .mask_i (dd_set_i[MASK_BIT]),
    .set_i  (dd_set_i[DD_W-1:0]),
    .cur_i  (dd_cur),
    .hit_o  (dd_hit)
  );

  assign match = (&tod_hit) & dd_hit;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               flag_q <= 1'b0;
    else if (tick_i && match)  flag_q <= 1'b1;
    else if (clr_i)            flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/alarm_int_route.sv
module alarm_int_route (
  input  logic a1_flag_i,
  input  logic a2_flag_i,
  input  logic a1_ie_i,
  input  logic a2_ie_i,
  input  logic intcn_i,
  output logic int_a_no,
  output logic int_b_no
);
  logic a1_act, a2_act;
  assign a1_act   = a1_flag_i & a1_ie_i;
  assign a2_act   = a2_flag_i & a2_ie_i;
  assign int_a_no = ~(a1_act | (intcn_i & a2_act));
  assign int_b_no = ~(~intcn_i & a2_act);
endmodule

// File: rtl/dual_alarm_cmp.sv
module dual_alarm_cmp
  import rtc_alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [VAL_W-1:0]  now_sec_i,
  input  logic [VAL_W-1:0]  now_min_i,
  input  logic [VAL_W-1:0]  now_hour_i,
  input  logic [DD_W-1:0]   now_day_i,
  input  logic [DD_W-1:0]   now_date_i,
  input  logic [BYTE_W-1:0] a1_sec_i,
  input  logic [BYTE_W-1:0] a1_min_i,
  input  logic [BYTE_W-1:0] a1_hour_i,
  input  logic [BYTE_W-1:0] a1_dd_i,
  input  logic [BYTE_W-1:0] a2_min_i,
  input  logic [BYTE_W-1:0] a2_hour_i,
  input  logic [BYTE_W-1:0] a2_dd_i,
  input  logic              a1_ie_i,
  input  logic              a2_ie_i,
  input  logic              intcn_i,
  input  logic              a1_clr_i,
  input  logic              a2_clr_i,
  output logic              a1_flag_o,
  output logic              a2_flag_o,
  output logic              int_a_no,
  output logic              int_b_no
);
  tod_now_t tod_now;
  tod_set_t a1_tod, a2_tod;

  assign tod_now = {now_hour_i, now_min_i, now_sec_i};
  assign a1_tod  = {a1_hour_i, a1_min_i, a1_sec_i};
  // alarm 2 seconds: unmasked, fixed at 00
  assign a2_tod  = {a2_hour_i, a2_min_i, alm_byte_t'(0)};

  alarm_unit i_alarm1 (
    .clk_i, .rst_ni, .tick_i,
    .clr_i      (a1_clr_i),
    .tod_set_i  (a1_tod),
    .tod_now_i  (tod_now),
    .dd_set_i   (a1_dd_i),
    .now_day_i  (now_day_i),
    .now_date_i (now_date_i),
    .flag_o     (a1_flag_o)
  );

  alarm_unit i_alarm2 (
    .clk_i, .rst_ni, .tick_i,
    .clr_i      (a2_clr_i),
    .tod_set_i  (a2_tod),
    .tod_now_i  (tod_now),
    .dd_set_i   (a2_dd_i),
    .now_day_i  (now_day_i),
    .now_date_i (now_date_i),
    .flag_o     (a2_flag_o)
  );

  alarm_int_route i_route (
    .a1_flag_i (a1_flag_o),
    .a2_flag_i (a2_flag_o),
    .a1_ie_i, .a2_ie_i, .intcn_i,
    .int_a_no, .int_b_no
  );
endmodule

// File: rtl/dual_alarm_cmp_chk.sv
module dual_alarm_cmp_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic [6:0] now_sec_i,
  input logic [6:0] now_min_i,
  input logic [6:0] now_hour_i,
  input logic [5:0] now_date_i,
  input logic [7:0] a1_sec_i,
  input logic [7:0] a1_min_i,
  input logic [7:0] a1_hour_i,
  input logic [7:0] a1_dd_i,
  input logic       a1_ie_i,
  input logic       a2_ie_i,
  input logic       intcn_i,
  input logic       a1_clr_i,
  input logic       a2_clr_i,
  input logic       a1_flag_o,
  input logic       a2_flag_o,
  input logic       int_a_no,
  input logic       int_b_no
);
  logic a1_exact;
  assign a1_exact = (a1_sec_i == {1'b0, now_sec_i}) && (a1_min_i == {1'b0, now_min_i})
                 && (a1_hour_i == {1'b0, now_hour_i}) && (a1_dd_i == {2'b00, now_date_i});

  assert_a1_needs_tick_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(a1_flag_o) |-> $past(tick_i));
  assert_a2_needs_tick_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(a2_flag_o) |-> $past(tick_i));
  assert_full_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && a1_exact) |=> a1_flag_o);
  assert_a2_zero_sec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(a2_flag_o) |-> ($past(now_sec_i) == 7'h00));
  assert_a1_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a1_flag_o && !a1_clr_i) |=> a1_flag_o);
  assert_a2_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a2_flag_o && !a2_clr_i) |=> a2_flag_o);
  assert_a1_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a1_clr_i && !tick_i) |=> !a1_flag_o);
  assert_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!a1_ie_i && !a2_ie_i) |-> (int_a_no && int_b_no));
  assert_shared_b_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intcn_i |-> int_b_no);
  assert_sep_a_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!intcn_i && !(a1_flag_o && a1_ie_i)) |-> int_a_no);
  assert_reset_R11: assert property (@(posedge clk_i)
    !rst_ni |-> (!a1_flag_o && !a2_flag_o && int_a_no && int_b_no));
endmodule

bind dual_alarm_cmp dual_alarm_cmp_chk i_chk (
  .clk_i, .rst_ni, .tick_i, .now_sec_i, .now_min_i, .now_hour_i, .now_date_i,
  .a1_sec_i, .a1_min_i, .a1_hour_i, .a1_dd_i, .a1_ie_i, .a2_ie_i, .intcn_i,
  .a1_clr_i, .a2_clr_i, .a1_flag_o, .a2_flag_o, .int_a_no, .int_b_no
);

// File: tb/test_dual_alarm_cmp.sv
module test_dual_alarm_cmp;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [6:0] n_sec, n_min, n_hour;
  logic [5:0] n_day, n_date;
  logic [7:0] a1s, a1m, a1h, a1d, a2m, a2h, a2d;
  logic       ie1 = 1'b0, ie2 = 1'b0, intcn = 1'b0, clr1 = 1'b0, clr2 = 1'b0;
  logic       f1, f2, pa_n, pb_n;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  dual_alarm_cmp i_dual_alarm_cmp (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .now_sec_i(n_sec), .now_min_i(n_min), .now_hour_i(n_hour),
    .now_day_i(n_day), .now_date_i(n_date),
    .a1_sec_i(a1s), .a1_min_i(a1m), .a1_hour_i(a1h), .a1_dd_i(a1d),
    .a2_min_i(a2m), .a2_hour_i(a2h), .a2_dd_i(a2d),
    .a1_ie_i(ie1), .a2_ie_i(ie2), .intcn_i(intcn),
    .a1_clr_i(clr1), .a2_clr_i(clr2),
    .a1_flag_o(f1), .a2_flag_o(f2), .int_a_no(pa_n), .int_b_no(pb_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // pulse tick for one cycle; flags valid at the following negedge
  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk) begin clr1 = 1'b1; clr2 = 1'b1; end
    @(negedge clk) begin clr1 = 1'b0; clr2 = 1'b0; end
  endtask

  // now 12:34:56, day 3, date 15; both alarms set to that time/date
  task automatic base();
    n_sec = 7'h56; n_min = 7'h34; n_hour = 7'h12; n_day = 6'h03; n_date = 6'h15;
    a1s = 8'h56; a1m = 8'h34; a1h = 8'h12; a1d = 8'h15;
    a2m = 8'h34; a2h = 8'h12; a2d = 8'h15;
    ie1 = 1'b0; ie2 = 1'b0; intcn = 1'b0;
    clear_all();
  endtask

  task automatic t_reset();
    chk("R11 a1 flag in reset", {7'b0, f1}, 8'h0);
    chk("R11 a2 flag in reset", {7'b0, f2}, 8'h0);
    chk("R11 pins in reset", {6'b0, pa_n, pb_n}, 8'h3);
  endtask

  task automatic t_no_tick();
    base();
    repeat (4) @(negedge clk);
    chk("R1 no flag without tick", {7'b0, f1}, 8'h0);
  endtask

  task automatic t_full_match();
    base();
    do_tick();
    chk("R2 full match sets a1", {7'b0, f1}, 8'h1);
    @(negedge clk);
    chk("R7 flag sticky", {7'b0, f1}, 8'h1);
    clear_all();
    chk("R7 clear drops flag", {7'b0, f1}, 8'h0);
    n_sec = 7'h57;
    do_tick();
    chk("R2 seconds mismatch no flag", {7'b0, f1}, 8'h0);
  endtask

  task automatic t_masks();
    base();
    a1s = 8'h80; n_sec = 7'h07;
    do_tick();
    chk("R3 seconds masked fires", {7'b0, f1}, 8'h1);
    clear_all();
    n_min = 7'h35;
    do_tick();
    chk("R3 minute mismatch blocks", {7'b0, f1}, 8'h0);
    a1s = 8'h80; a1m = 8'h80; a1h = 8'h80; a1d = 8'h80;
    n_hour = 7'h09; n_date = 6'h01;
    do_tick();
    chk("R3 all masked fires every tick", {7'b0, f1}, 8'h1);
  endtask

  task automatic t_daydate();
    base();
    a1d = 8'h43;  // select day, value 3
    do_tick();
    chk("R4 day select matches day", {7'b0, f1}, 8'h1);
    clear_all();
    n_day = 6'h04;
    do_tick();
    chk("R4 day select ignores date", {7'b0, f1}, 8'h0);
    a1d = 8'h15; n_day = 6'h04;
    do_tick();
    chk("R4 date select matches date", {7'b0, f1}, 8'h1);
  endtask

  task automatic t_hours();
    base();
    a1h = 8'h72; n_hour = 7'h52;
    do_tick();
    chk("R6 mode bit differs no match", {7'b0, f1}, 8'h0);
    n_hour = 7'h72;
    do_tick();
    chk("R6 12h PM exact match", {7'b0, f1}, 8'h1);
  endtask

  task automatic t_alarm2();
    base();
    n_sec = 7'h01;
    do_tick();
    chk("R5 a2 silent at seconds 01", {7'b0, f2}, 8'h0);
    n_sec = 7'h00;
    do_tick();
    chk("R5 a2 fires at seconds 00", {7'b0, f2}, 8'h1);
    clear_all();
    a2m = 8'h80; a2h = 8'h80; n_min = 7'h59; n_hour = 7'h03;
    do_tick();
    chk("R5 a2 masked fires at 00", {7'b0, f2}, 8'h1);
  endtask

  task automatic t_set_wins();
    base();
    do_tick();
    @(negedge clk) begin tick = 1'b1; clr1 = 1'b1; end
    @(negedge clk) begin tick = 1'b0; clr1 = 1'b0; end
    chk("R8 set beats clear", {7'b0, f1}, 8'h1);
  endtask

  task automatic t_irq();
    base();
    n_sec = 7'h00; a1s = 8'h00;
    do_tick();
    chk("R9 flags set enables off", {6'b0, pa_n, pb_n}, 8'h3);
    ie1 = 1'b1;
    @(negedge clk);
    chk("R10 separate a1 on pin A", {6'b0, pa_n, pb_n}, 8'h1);
    ie1 = 1'b0; ie2 = 1'b1;
    @(negedge clk);
    chk("R10 separate a2 on pin B", {6'b0, pa_n, pb_n}, 8'h2);
    intcn = 1'b1;
    @(negedge clk);
    chk("R10 shared a2 on pin A", {6'b0, pa_n, pb_n}, 8'h1);
    @(negedge clk) clr2 = 1'b1;
    @(negedge clk) clr2 = 1'b0;
    chk("R9 cleared flag releases pin", {6'b0, pa_n, pb_n}, 8'h3);
  endtask

  initial begin
    n_sec = '0; n_min = '0; n_hour = '0; n_day = '0; n_date = '0;
    a1s = '0; a1m = '0; a1h = '0; a1d = '0; a2m = '0; a2h = '0; a2d = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_no_tick();
    t_full_match();
    t_masks();
    t_daydate();
    t_hours();
    t_alarm2();
    t_set_wins();
    t_irq();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule